// File: doc/BRIEF.md
# Register-Window Burst Sequencer

This block lets a DMA engine move a run of consecutive peripheral registers through one fixed bus address. Software first programs a control word that holds a starting register number and a transfer count. The DMA engine then reads or writes the window address over and over. Each of those accesses is redirected to the register at start plus a running position, and the position advances by one after each access. After the programmed number of transfers the position returns to zero, so the next burst covers the same run again.

The block has a plain register bus (address, read strobe, write strobe, write data, combinational read data). Bus addresses 0 to 31 reach the 32-entry, 16-bit target register file directly. Address 32 is the control word and address 33 is the window. All other addresses read as zero. The register file here only stands in for the peripheral's real registers.

Top module: `dws_window_top`

## Requirements
- R1: After reset the control word, every file entry and the running position are zero, so the first window read returns entry 0, which is zero.
- R2: The control word at address 32 keeps the length code in bits 12:8 and the start register in bits 4:0. Bits 15:13 and 7:5 always read as zero.
- R3: A write to the window (address 33) stores the write data into entry start+position, and the position then advances by one.
- R4: A read of the window returns entry start+position in the same cycle, and the position then advances by one.
- R5: A length code L (0..17) gives L+1 transfers. The access made at position L returns the position to 0, so code 0 keeps hitting the start register.
- R6: Length codes from 18 to 31 behave like code 17, which gives eighteen transfers per burst.
- R7: Any write to the control word sets the position to zero.
- R8: When start+position is above 31, a window read returns zero and a window write changes no entry. The position still advances.
- R9: Bus addresses 0 to 31 read and write file entries directly and leave the position unchanged. Idle cycles also leave it unchanged.
- R10: Reads of addresses 34 to 63 return zero. When the read strobe is low, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 6 | Register bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as bus_rd |

## Verification
The window is driven with short bursts (code 0 and code 3), with the longest legal burst, and with an oversized code. Together these separate an off-by-one in the wrap point from a missing clamp. Bursts placed near the top of the file push start+position past entry 31, which shows whether out-of-range accesses are masked while the position still advances. Direct file accesses and control writes are mixed in the middle of bursts, which shows whether the position moves only on window accesses and is cleared by control writes. A behavioural model predicts the read data on every cycle.

// File: rtl/dws_pkg.sv
package dws_pkg;
  typedef enum logic [1:0] {
    SEL_FILE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_WIN  = 2'd2,
    SEL_NONE = 2'd3
  } dws_sel_e;
endpackage

// File: rtl/dws_ctrl_reg.sv
module dws_ctrl_reg #(
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 5,
  parameter int LEN_LSB = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  output logic [FIELD_W-1:0] len_code,
  output logic [FIELD_W-1:0] start_reg,
  output logic [DATA_W-1:0]  rd_word
);
  logic [FIELD_W-1:0] len_d, start_d;

  always_comb begin
    len_d   = len_code;
    start_d = start_reg;
    if (wr_en) begin
      len_d   = wdata[LEN_LSB +: FIELD_W];
      start_d = wdata[FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_code  <= '0;
      start_reg <= '0;
    end else if (wr_en) begin
      len_code  <= len_d;
      start_reg <= start_d;
    end
  end

  always_comb begin
    rd_word = '0;
    rd_word[LEN_LSB +: FIELD_W] = len_code;
    rd_word[FIELD_W-1:0]        = start_reg;
  end
endmodule

// File: rtl/dws_index_seq.sv
module dws_index_seq #(
  parameter int FIELD_W  = 5,
  parameter int MAX_CODE = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               step,
  input  logic [FIELD_W-1:0] len_code,
  output logic [FIELD_W-1:0] pos
);
  localparam logic [FIELD_W-1:0] MAX_C = FIELD_W'(MAX_CODE);

  logic [FIELD_W-1:0] last_pos;
  logic [FIELD_W-1:0] pos_d;
  logic               pos_en;

  always_comb begin
    last_pos = (len_code > MAX_C) ? MAX_C : len_code;
    pos_en   = clear | step;
    pos_d    = pos;
    if (clear)                pos_d = '0;
    else if (pos >= last_pos) pos_d = '0;
    else                      pos_d = pos + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos <= '0;
    else if (pos_en) pos <= pos_d;
  end
endmodule

// File: rtl/dws_regfile.sv
module dws_regfile #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              in_range;

  assign in_range = (int'(addr) < DEPTH);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = we && in_range && (int'(addr) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem[g] <= '0;
      else if (ent_en) mem[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++)
      if (in_range && int'(addr) == i) rdata = mem[i];
  end
endmodule

// File: rtl/dws_window_top.sv
module dws_window_top #(
  parameter int DATA_W    = 16,
  parameter int FIELD_W   = 5,
  parameter int DEPTH     = 32,
  parameter int ADDR_W    = 6,
  parameter int MAX_CODE  = 17,
  parameter int CTRL_ADDR = 32,
  parameter int WIN_ADDR  = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  import dws_pkg::*;
  localparam int TW = FIELD_W + 1;

  logic [1:0]          rst_pipe;
  logic                rst_sync_n;
  dws_sel_e            sel;
  logic                ctrl_we, win_acc, file_we;
  logic [FIELD_W-1:0]  len_code, start_reg, pos;
  logic [DATA_W-1:0]   ctrl_word, file_rdata;
  logic [TW-1:0]       win_tgt, file_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    if (int'(bus_addr) < DEPTH)          sel = SEL_FILE;
    else if (int'(bus_addr) == CTRL_ADDR) sel = SEL_CTRL;
    else if (int'(bus_addr) == WIN_ADDR)  sel = SEL_WIN;
    else                                  sel = SEL_NONE;
  end

  assign ctrl_we = bus_wr && (sel == SEL_CTRL);
  assign win_acc = (bus_rd || bus_wr) && (sel == SEL_WIN);
  assign win_tgt = TW'(start_reg) + TW'(pos);

  always_comb begin
    file_addr = TW'(bus_addr[FIELD_W-1:0]);
    file_we   = bus_wr && (sel == SEL_FILE);
    if (sel == SEL_WIN) begin
      file_addr = win_tgt;
      file_we   = bus_wr;
    end
  end

  dws_ctrl_reg #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .LEN_LSB(8)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(ctrl_we), .wdata(bus_wdata),
    .len_code(len_code), .start_reg(start_reg), .rd_word(ctrl_word)
  );

  dws_index_seq #(.FIELD_W(FIELD_W), .MAX_CODE(MAX_CODE)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .clear(ctrl_we), .step(win_acc),
    .len_code(len_code), .pos(pos)
  );

  dws_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(TW)) u_file (
    .clk(clk), .rst_n(rst_sync_n), .we(file_we), .addr(file_addr),
    .wdata(bus_wdata), .rdata(file_rdata)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_FILE, SEL_WIN: bus_rdata = file_rdata;
        SEL_CTRL:          bus_rdata = ctrl_word;
        default:           bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dws_window_chk.sv
module dws_window_chk #(
  parameter int DATA_W   = 16,
  parameter int FIELD_W  = 5,
  parameter int ADDR_W   = 6,
  parameter int MAX_CODE = 17
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               ctrl_we,
  input logic               win_acc,
  input logic [FIELD_W-1:0] len_code,
  input logic [FIELD_W-1:0] pos,
  input logic [FIELD_W:0]   win_tgt
);
  logic [FIELD_W-1:0] lim;
  assign lim = (int'(len_code) > MAX_CODE) ? FIELD_W'(MAX_CODE) : len_code;

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pos <= lim); // R6
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (win_acc && pos == lim) |=> pos == '0); // R5
  AST_CTRL_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_we |=> pos == '0); // R7
  AST_POS_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctrl_we && !win_acc) |=> $stable(pos)); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && int'(bus_addr) == 32) |-> (bus_rdata[15:13] == '0 && bus_rdata[7:5] == '0)); // R2
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && win_acc && int'(win_tgt) > 31) |-> bus_rdata == '0); // R8
endmodule

bind dws_window_top dws_window_chk #(
  .DATA_W(DATA_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W), .MAX_CODE(MAX_CODE)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .ctrl_we(ctrl_we), .win_acc(win_acc),
  .len_code(len_code), .pos(pos), .win_tgt(win_tgt)
);

// File: tb/sim_dws_window_top.sv
module sim_dws_window_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [15:0] m_file [32];
  int m_len, m_start, m_pos;

  always #4 clk = ~clk;

  dws_window_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [15:0] model_read(input int a);
    int t;
    if (a < 32) return m_file[a];
    if (a == 32) return 16'((m_len << 8) | m_start);
    if (a == 33) begin
      t = m_start + m_pos;
      return (t < 32) ? m_file[t] : 16'h0;
    end
    return 16'h0;
  endfunction

  task automatic model_step(input bit rd, input bit wr, input int a, input logic [15:0] d);
    int t, lim;
    if (wr && a < 32) m_file[a] = d;
    else if (wr && a == 32) begin
      m_len = int'(d[12:8]); m_start = int'(d[4:0]); m_pos = 0;
    end else if ((rd || wr) && a == 33) begin
      t = m_start + m_pos;
      if (wr && t < 32) m_file[t] = d;
      lim = (m_len > 17) ? 17 : m_len;
      m_pos = (m_pos == lim) ? 0 : m_pos + 1;
    end
  endtask

  task automatic cyc(input bit rd, input bit wr, input int a, input logic [15:0] d, input string tag);
    logic [15:0] exp;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a[5:0]; bus_wdata = d;
    #2;
    exp = rd ? model_read(a) : 16'h0;
    n_checks++;
    if (bus_rdata !== exp) begin
      n_errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
    @(posedge clk);
    model_step(rd, wr, a, d);
  endtask

  task automatic rd(input int a, input string tag);
    cyc(1'b1, 1'b0, a, 16'h0, tag);
  endtask
  task automatic wr(input int a, input logic [15:0] d, input string tag);
    cyc(1'b0, 1'b1, a, d, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m_file[i] = 16'h0;
    m_len = 0; m_start = 0; m_pos = 0;
    bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state
    rd(32, "R1"); rd(5, "R1"); rd(33, "R1");
    wr(32, 16'h0000, "R7");
    // R9: direct file fill
    for (int i = 0; i < 32; i++) wr(i, 16'(i * 16'h0111 + 16'h00A5), "R9");
    rd(7, "R9"); rd(31, "R9");
    // R2: reserved bits dropped
    wr(32, 16'hFFFF, "R2"); rd(32, "R2");
    // R4/R5: code 3, start 4, six reads wrap
    wr(32, 16'h0304, "R5");
    for (int i = 0; i < 6; i++) rd(33, "R4");
    // R9: direct access and idle mid-burst do not move the position
    rd(10, "R9"); cyc(1'b0, 1'b0, 0, 16'h0, "R10"); rd(33, "R9");
    // R3: window writes
    wr(32, 16'h0208, "R3");
    for (int i = 0; i < 4; i++) wr(33, 16'(16'hC000 + i), "R3");
    for (int i = 8; i < 12; i++) rd(i, "R3");
    // R5: code 0 keeps hitting start
    wr(32, 16'h0002, "R5");
    for (int i = 0; i < 3; i++) rd(33, "R5");
    // R6: oversized code clamps to 18
    wr(32, 16'h1F00, "R6");
    for (int i = 0; i < 20; i++) rd(33, "R6");
    // R5: max legal code with start 10
    wr(32, 16'h110A, "R5");
    for (int i = 0; i < 19; i++) rd(33, "R5");
    // R7: control write mid-burst clears position
    wr(32, 16'h0500, "R7");
    rd(33, "R7"); rd(33, "R7");
    wr(32, 16'h0500, "R7"); rd(33, "R7");
    // R8: out of range past entry 31
    wr(32, 16'h051E, "R8");
    for (int i = 0; i < 6; i++) wr(33, 16'(16'hBEE0 + i), "R8");
    rd(30, "R8"); rd(31, "R8"); rd(0, "R8"); rd(1, "R8");
    for (int i = 0; i < 7; i++) rd(33, "R8");
    // R10: unmapped reads
    rd(34, "R10"); rd(50, "R10"); rd(63, "R10");
    wr(50, 16'h1234, "R10"); rd(50, "R10"); rd(32, "R10");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule